// File: doc/BRIEF.md
# Preamble-Led Wireless Frame Serializer

This block turns one frame, handed over in parallel by a host, into a single serial line at a fixed bit rate. The line is meant for a radio transceiver whose far-end receiver oversamples the signal. That receiver first locks onto an alternating training pattern and then collects bytes. The host presents a start (sync) byte, an address byte and a payload length, then pulses `start`. The block latches these values and raises `busy`. It sends the training pattern, the sync byte, the address, the payload bytes and a 16-bit CRC back to back. It adds no start or stop bits and leaves no gaps between bits.

Payload bytes are pulled from the host through a show-ahead interface. The host keeps the next payload byte on `payData`. The block strobes `payNext` in the cycle it takes that byte, and the host then moves to the following byte. The bit period is a whole number of clocks, set by `CLKS_PER_BIT`. At the end of the frame the line drops low, `busy` falls and `done` pulses once.

Top module: `frame_serializer`

## Requirements
- R1: During and after reset, `txLine`, `busy`, `done` and `payNext` are all low.
- R2: The frame opens with `PRE_BITS` preamble bits (at least 8) alternating 1,0,1,0,…, and the first bit is a 1.
- R3: After the preamble the line carries the sync byte, the address byte, the payload bytes in pull order, the CRC high byte and the CRC low byte. Every byte goes out most significant bit first, with no framing bits and no gaps.
- R4: Every bit holds the line steady for exactly `CLKS_PER_BIT` clock cycles.
- R5: The CRC uses polynomial 0x1021 and starts from 0xFFFF. It is computed MSB first, without reflection and without a final XOR, over the sync byte, the address and the payload. For a sync byte 0x31, address 0x32 and payload 0x33..0x39 the CRC is 0x29B1.
- R6: The payload length is `payLen`, sampled when `start` is accepted. A value of 0 is treated as 1, and a value above `MAX_PAY` (default 100) is treated as `MAX_PAY`.
- R7: `payNext` is high for exactly one cycle per payload byte, in the last cycle of the bit that precedes that byte. In that cycle `payData` must hold the byte.
- R8: `busy` stays high for exactly `CLKS_PER_BIT × (PRE_BITS + 8·(len+4))` cycles, starting with the first preamble bit. Whenever `busy` is low, `txLine` is low.
- R9: `done` is a one-cycle pulse. It is issued in the first cycle in which `busy` is low again after a frame.
- R10: A `start` pulse that arrives while `busy` is high is ignored, along with the header and length inputs present with it. The frame in progress and its single `done` pulse are unchanged.
- R11: When `start` is high while idle, `busy` and the first preamble bit appear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, sampled while idle |
| syncByte | input | 8 | Start-of-frame marker byte, latched on start |
| addrByte | input | 8 | Address byte, latched on start |
| payLen | input | LEN_W (7) | Payload byte count, latched and clamped on start |
| payData | input | 8 | Current payload byte (show-ahead) |
| payNext | output | 1 | Payload byte taken this cycle |
| txLine | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The serializer is driven with frames whose sync and address bytes range from all-zeros and all-ones to mixed patterns. Their payloads run from a single byte through the full 100 bytes. This separates errors in bit order, byte order and length handling. Each frame is compared cycle by cycle against a stream built from the requirements, so a wrong bit period shows up apart from a wrong bit value. A frame with a known CRC result pins down the checksum convention independently of the bench's own CRC model. Clamped lengths and a mid-frame start pulse with changed header inputs show that the latching and clamping rules hold.

// File: rtl/frame_serializer_pkg.sv
package frame_serializer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SYNC, PH_ADDR, PH_PAY, PH_CRCH, PH_CRCL
  } phase_t;

  typedef enum logic [2:0] {
    SEL_SYNC, SEL_ADDR, SEL_PAY, SEL_CRCH, SEL_CRCL
  } sel_t;

  // Strobes from the sequencer to the datapath, valid for one cycle.
  typedef struct packed {
    logic go;      // latch header, seed CRC, drive first preamble bit
    logic pre;     // drive next preamble bit
    logic preVal;  // its value
    logic load;    // put a new byte on the line
    sel_t sel;     // which byte
    logic shift;   // next bit of the current byte
    logic stop;    // return line to idle
  } strobe_t;

  // One byte through the CCITT polynomial, MSB first.
  function automatic logic [15:0] crcByte(input logic [15:0] crcIn, input logic [7:0] d);
    logic [15:0] c;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/frame_serializer_ctrl.sv
module frame_serializer_ctrl
  import frame_serializer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 100,
  parameter int PRE_BITS     = 16,
  parameter int MAX_PAY      = 100,
  parameter int LEN_W        = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] payLen,
  output strobe_t          ctl,
  output logic             busy,
  output logic             done
);
  localparam int TMR_W = $clog2(CLKS_PER_BIT);
  localparam int IDX_W = ($clog2(PRE_BITS) > 3) ? $clog2(PRE_BITS) : 3;
  localparam logic [TMR_W-1:0] TMR_MAX  = TMR_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_BITS - 1);
  localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(7);

  phase_t           phase, phaseN;
  logic [TMR_W-1:0] bitTmr, tmrN;
  logic [IDX_W-1:0] bitIdx, idxN;
  logic [LEN_W-1:0] byteCnt, cntN, lenReg, lenN, lenClamped;
  logic             doneN;

  always_comb begin
    if (payLen == '0)                      lenClamped = LEN_W'(1);
    else if (payLen > LEN_W'(MAX_PAY))     lenClamped = LEN_W'(MAX_PAY);
    else                                   lenClamped = payLen;
  end

  always_comb begin
    ctl    = '0;
    phaseN = phase;
    tmrN   = bitTmr;
    idxN   = bitIdx;
    cntN   = byteCnt;
    lenN   = lenReg;
    doneN  = 1'b0;
    if (phase == PH_IDLE) begin
      if (start) begin
        ctl.go = 1'b1;
        phaseN = PH_PRE;
        tmrN   = TMR_MAX;
        idxN   = '0;
        cntN   = '0;
        lenN   = lenClamped;
      end
    end else if (bitTmr != '0) begin
      tmrN = bitTmr - 1'b1;
    end else begin
      tmrN = TMR_MAX;
      idxN = bitIdx + 1'b1;
      if (phase == PH_PRE) begin
        if (bitIdx == PRE_LAST) begin
          ctl.load = 1'b1; ctl.sel = SEL_SYNC; phaseN = PH_SYNC; idxN = '0;
        end else begin
          ctl.pre = 1'b1; ctl.preVal = bitIdx[0];
        end
      end else if (bitIdx != BIT_LAST) begin
        ctl.shift = 1'b1;
      end else begin
        idxN = '0;
        unique case (phase)
          PH_SYNC: begin ctl.load = 1'b1; ctl.sel = SEL_ADDR; phaseN = PH_ADDR; end
          PH_ADDR: begin ctl.load = 1'b1; ctl.sel = SEL_PAY;  phaseN = PH_PAY;  end
          PH_PAY: begin
            ctl.load = 1'b1;
            if (byteCnt == lenReg - LEN_W'(1)) begin
              ctl.sel = SEL_CRCH; phaseN = PH_CRCH;
            end else begin
              ctl.sel = SEL_PAY;  cntN = byteCnt + 1'b1;
            end
          end
          PH_CRCH: begin ctl.load = 1'b1; ctl.sel = SEL_CRCL; phaseN = PH_CRCL; end
          default: begin ctl.stop = 1'b1; phaseN = PH_IDLE; doneN = 1'b1; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitTmr  <= '0;
      bitIdx  <= '0;
      byteCnt <= '0;
      lenReg  <= LEN_W'(1);
      done    <= 1'b0;
    end else begin
      phase   <= phaseN;
      bitTmr  <= tmrN;
      bitIdx  <= idxN;
      byteCnt <= cntN;
      lenReg  <= lenN;
      done    <= doneN;
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/frame_serializer_dp.sv
module frame_serializer_dp
  import frame_serializer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    ctl,
  input  logic [7:0] syncByte,
  input  logic [7:0] addrByte,
  input  logic [7:0] payData,
  output logic       txLine
);
  logic [7:0]  syncReg, addrReg, shReg, selByte;
  logic [15:0] crc;
  logic        isData;

  always_comb begin
    unique case (ctl.sel)
      SEL_SYNC: selByte = syncReg;
      SEL_ADDR: selByte = addrReg;
      SEL_PAY:  selByte = payData;
      SEL_CRCH: selByte = crc[15:8];
      default:  selByte = crc[7:0];
    endcase
    isData = (ctl.sel == SEL_SYNC) || (ctl.sel == SEL_ADDR) || (ctl.sel == SEL_PAY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '0;
      addrReg <= '0;
      shReg   <= '0;
      crc     <= 16'hFFFF;
      txLine  <= 1'b0;
    end else begin
      if (ctl.go) begin
        syncReg <= syncByte;
        addrReg <= addrByte;
        crc     <= 16'hFFFF;
        txLine  <= 1'b1;
      end
      if (ctl.pre) txLine <= ctl.preVal;
      if (ctl.load) begin
        txLine <= selByte[7];
        shReg  <= {selByte[6:0], 1'b0};
        if (isData) crc <= crcByte(crc, selByte);
      end
      if (ctl.shift) begin
        txLine <= shReg[7];
        shReg  <= {shReg[6:0], 1'b0};
      end
      if (ctl.stop) txLine <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_serializer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 100,
  parameter int PRE_BITS     = 16,
  parameter int MAX_PAY      = 100,
  parameter int LEN_W        = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       syncByte,
  input  logic [7:0]       addrByte,
  input  logic [LEN_W-1:0] payLen,
  input  logic [7:0]       payData,
  output logic             payNext,
  output logic             txLine,
  output logic             busy,
  output logic             done
);
  strobe_t ctl;

  frame_serializer_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .PRE_BITS(PRE_BITS),
    .MAX_PAY(MAX_PAY), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .payLen(payLen),
    .ctl(ctl), .busy(busy), .done(done)
  );

  frame_serializer_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .syncByte(syncByte), .addrByte(addrByte), .payData(payData),
    .txLine(txLine)
  );

  assign payNext = ctl.load && (ctl.sel == SEL_PAY);

endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk #(
  parameter int CLKS_PER_BIT = 100
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic txLine,
  input logic payNext
);
  localparam int CW = $clog2(CLKS_PER_BIT);

  // Cycle position inside the current bit, counted from the first busy cycle.
  logic [CW-1:0] bitPos;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         bitPos <= '0;
    else if (!busy || bitPos == CW'(CLKS_PER_BIT - 1)) bitPos <= '0;
    else                                               bitPos <= bitPos + 1'b1;
  end

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitPos != '0) |-> $stable(txLine));
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txLine);
  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> txLine);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R7
  pay_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    payNext |-> (busy && bitPos == CW'(CLKS_PER_BIT - 1)));

endmodule

bind frame_serializer frame_serializer_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .txLine(txLine), .payNext(payNext)
);

// File: tb/frame_serializer_bench.sv
`timescale 1ns/100ps
module frame_serializer_bench;
  localparam int CPB  = 3;
  localparam int PRE  = 12;
  localparam int MAXP = 100;
  localparam int LW   = 7;

  // {sync, addr, len, seed}
  localparam logic [31:0] VEC [5] = '{
    {8'h33, 8'h37, 8'd10,  8'h00},
    {8'hA5, 8'h5A, 8'd1,   8'hFF},
    {8'h00, 8'hFF, 8'd4,   8'h80},
    {8'hFF, 8'h00, 8'd100, 8'h11},
    {8'h7E, 8'h01, 8'd2,   8'hC3}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] syncByte = '0, addrByte = '0;
  logic [LW-1:0] payLen = '0;
  logic [7:0] payData;
  logic payNext, txLine, busy, done;
  logic [7:0] payMem [0:127];
  logic [6:0] ptr;
  int checks = 0, errors = 0;
  int busyTot = 0, doneTot = 0, nextTot = 0;
  bit finished = 0;
  bit expBits [0:1023];
  bit gotBits [0:1023];

  always #2.5 clk = ~clk;

  frame_serializer #(.CLKS_PER_BIT(CPB), .PRE_BITS(PRE), .MAX_PAY(MAXP), .LEN_W(LW))
    u_frame_serializer (
      .clk(clk), .rstN(rstN), .start(start), .syncByte(syncByte), .addrByte(addrByte),
      .payLen(payLen), .payData(payData), .payNext(payNext), .txLine(txLine),
      .busy(busy), .done(done));

  assign payData = payMem[ptr];
  always @(posedge clk) begin
    if (!rstN)               ptr <= '0;
    else if (start && !busy) ptr <= '0;
    else if (payNext)        ptr <= ptr + 1'b1;
  end

  always @(negedge clk) begin
    if (busy)    busyTot++;
    if (done)    doneTot++;
    if (payNext) nextTot++;
  end

  function automatic logic [15:0] refCrc(input logic [15:0] c0, input logic [7:0] d);
    logic [15:0] c = c0;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fillSeed(input logic [7:0] seed);
    for (int k = 0; k < 128; k++) payMem[k] = seed + 8'(k * 37);
  endtask

  task automatic runFrame(input logic [7:0] s, input logic [7:0] a, input logic [LW-1:0] lenIn,
                          input int eff, input bit inject, input string tag);
    logic [7:0] fb [0:103];
    logic [15:0] c;
    int pos, n, mism, badPre, b0, d0, p0;
    fb[0] = s; fb[1] = a;
    for (int k = 0; k < eff; k++) fb[2 + k] = payMem[k];
    c = 16'hFFFF;
    for (int k = 0; k < eff + 2; k++) c = refCrc(c, fb[k]);
    fb[eff + 2] = c[15:8];
    fb[eff + 3] = c[7:0];
    pos = 0;
    for (int i = 0; i < PRE; i++) begin expBits[pos] = (i % 2 == 0); pos++; end
    for (int k = 0; k < eff + 4; k++)
      for (int b = 7; b >= 0; b--) begin expBits[pos] = fb[k][b]; pos++; end
    n = pos;
    b0 = busyTot; d0 = doneTot; p0 = nextTot;
    mism = 0; badPre = 0;

    @(negedge clk);
    syncByte = s; addrByte = a; payLen = lenIn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R11", {tag, " busy one cycle after start"}, busy, 1);
    for (int j = 0; j < n; j++) begin
      for (int cy = 0; cy < CPB; cy++) begin
        if (inject && j == 20 && cy == 0) begin
          start = 1'b1; syncByte = ~s; addrByte = ~a; payLen = 7'd3;
        end else if (inject && j == 20 && cy == 1) begin
          start = 1'b0;
        end
        if (cy == CPB / 2) gotBits[j] = txLine;
        if (txLine !== expBits[j]) begin
          mism++;
          if (j < PRE) badPre++;
        end
        @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    check(badPre == 0, "R2", {tag, " preamble mismatching cycles"}, badPre, 0);
    check(mism == 0, "R3/R4", {tag, " stream mismatching cycles"}, mism, 0);
    check(busyTot - b0 == n * CPB, "R8", {tag, " busy cycles"}, busyTot - b0, n * CPB);
    check(doneTot - d0 == 1, "R9", {tag, " done pulses"}, doneTot - d0, 1);
    check(nextTot - p0 == eff, "R7", {tag, " payNext pulses"}, nextTot - p0, eff);
    check(txLine === 1'b0 && busy === 1'b0, "R8", {tag, " idle after frame"}, {txLine, busy}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] crcSeen;
    int n;
    fillSeed(8'h00);
    repeat (3) @(negedge clk);
    // R1 during reset
    check({txLine, busy, done, payNext} === 4'b0, "R1", "outputs in reset", {txLine, busy, done, payNext}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({txLine, busy, done, payNext} === 4'b0, "R1", "outputs after reset", {txLine, busy, done, payNext}, 0);

    // Vector table walk (R2 R3 R4 R5 R7 R8 R9 R11)
    for (int v = 0; v < 5; v++) begin
      fillSeed(VEC[v][7:0]);
      runFrame(VEC[v][31:24], VEC[v][23:16], VEC[v][14:8], int'(VEC[v][15:8]), 1'b0,
               $sformatf("vec%0d", v));
    end

    // R5: known checksum value
    for (int k = 0; k < 7; k++) payMem[k] = 8'h33 + 8'(k);
    runFrame(8'h31, 8'h32, 7'd7, 7, 1'b0, "crcKnown");
    n = PRE + 8 * (7 + 4);
    for (int i = 0; i < 16; i++) crcSeen[15 - i] = gotBits[n - 16 + i];
    check(crcSeen == 16'h29B1, "R5", "known CRC on line", crcSeen, 16'h29B1);

    // R6: length clamps
    fillSeed(8'h5C);
    runFrame(8'h96, 8'h69, 7'd0, 1, 1'b0, "R6 len0");
    fillSeed(8'h21);
    runFrame(8'h3C, 8'hC3, 7'd127, 100, 1'b0, "R6 len127");

    // R10: start while busy is ignored
    fillSeed(8'h44);
    runFrame(8'hE1, 8'h1E, 7'd5, 5, 1'b1, "R10 restart");
    repeat (2 * CPB) @(negedge clk);
    check(busy === 1'b0 && doneTot > 0, "R10", "no second frame after ignored start", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule